// File: doc/BRIEF.md
# Data-Space Address Decoder with External SRAM Port

This block sits on the data side of an 8-bit processor. It takes one 16-bit data address with read and write requests and steers the access to one of four on-chip targets: the register file, the standard I/O window, the extended I/O window or the internal SRAM. Any address above the top of the internal SRAM goes to an external asynchronous SRAM bus. The block drives that bus with a latched address, latched write data and active-low read and write strobes.

An internal access finishes in the cycle it is issued. An external access holds the processor with a stall output for one cycle plus a programmable number of wait states. The read data is taken from the external bus in the cycle the stall drops. A compatibility input selects a legacy layout. That layout has no extended I/O window and its internal SRAM ends at a lower address, so the external range starts lower. External memory answers only while an enable input is high. Otherwise an external-range access selects nothing and reports a decode error.

Top module: `data_space_decoder`

## Requirements
- R1: With `compat_i` low, a request selects one target on `sel_o`. Addresses 0x0000..0x001F select the register file (`sel_o` bit 0). 0x0020..0x005F select standard I/O (bit 1). 0x0060..0x00FF select extended I/O (bit 2). 0x0100..0x10FF select internal SRAM (bit 3). At most one bit of `sel_o` is high, and `sel_o` is zero without a request.
- R2: With `compat_i` high, extended I/O is never selected. 0x0000..0x001F select the register file, 0x0020..0x005F select standard I/O and 0x0060..0x0FFF select internal SRAM.
- R3: With `xmem_en_i` high, every address above the internal SRAM up to 0xFFFF selects no on-chip target and starts an external bus access.
- R4: With `xmem_en_i` low, an external-range request selects no target. In that cycle the strobes stay high, `stall_o` is low, `rdata_o` is 0x00 and `decode_err_o` is high.
- R5: `ext_rd_no` and `ext_wr_no` stay high in every cycle of an internal access.
- R6: For an external access with wait setting `wait_i` = w (0..3), `stall_o` is high for exactly w+1 consecutive cycles, starting in the request cycle. The access therefore takes w+1 clocks more than an internal one.
- R7: The selected strobe (read or write, never both) is low for exactly w+1 cycles. It starts in the cycle after the request and ends in the last cycle of the access. `ext_addr_o` and `ext_wdata_o` hold the request's address and data throughout.
- R8: External read data on `ext_rdata_i` appears on `rdata_o` in the final cycle of the access. An external write stores `wdata_i` at that address.
- R9: `wait_i` and `compat_i` are sampled only in the request cycle. Changing them during an access does not change its length or its target.
- R10: An internal read returns the selected target's read-data input on `rdata_o` in the same cycle.
- R11: During reset and after it, with no request, `stall_o` is low, both strobes are high and `sel_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Data address |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| wdata_i | input | 8 | Write data |
| compat_i | input | 1 | Legacy layout select |
| xmem_en_i | input | 1 | External memory enable |
| wait_i | input | 2 | External wait states |
| rdata_o | output | 8 | Read data to the processor |
| stall_o | output | 1 | Hold the processor |
| decode_err_o | output | 1 | Access to disabled external range |
| sel_o | output | 4 | One-hot on-chip target select |
| rf_rdata_i | input | 8 | Register file read data |
| io_rdata_i | input | 8 | Standard I/O read data |
| xio_rdata_i | input | 8 | Extended I/O read data |
| sram_rdata_i | input | 8 | Internal SRAM read data |
| ext_addr_o | output | 16 | External bus address |
| ext_wdata_o | output | 8 | External bus write data |
| ext_rdata_i | input | 8 | External bus read data |
| ext_rd_no | output | 1 | External read strobe, active low |
| ext_wr_no | output | 1 | External write strobe, active low |

## Verification
The assertions check every cycle for these properties:
- the target select is one-hot;
- both strobes stay quiet whenever an on-chip target is selected or a decode error is flagged;
- the two strobes are never low together;
- the external address and data stay frozen while a strobe is low;
- a strobe begins only after a stalled cycle and never ends while the stall is still high.

Only the bench's scenarios can show the items below:
- the exact region boundaries in both layouts, swept address by address;
- the stall and strobe counts for each wait setting;
- the external data round trips;
- mode and wait changes in the middle of an access having no effect.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    RGN_RF   = 3'd0,
    RGN_IO   = 3'd1,
    RGN_XIO  = 3'd2,
    RGN_SRAM = 3'd3,
    RGN_EXT  = 3'd4
  } region_e;
endpackage

// File: rtl/dsd_region_decode.sv
module dsd_region_decode
  import dsd_pkg::*;
#(
  parameter int unsigned AW               = 16,
  parameter int unsigned RF_LAST          = 32'h001F,
  parameter int unsigned IO_LAST          = 32'h005F,
  parameter int unsigned XIO_LAST         = 32'h00FF,
  parameter int unsigned SRAM_LAST_NORM   = 32'h10FF,
  parameter int unsigned SRAM_LAST_COMPAT = 32'h0FFF
) (
  input  logic [AW-1:0] addr_i,
  input  logic          compat_i,
  output region_e       region_o
);
  localparam logic [AW-1:0] RfL  = AW'(RF_LAST);
  localparam logic [AW-1:0] IoL  = AW'(IO_LAST);
  localparam logic [AW-1:0] XioL = AW'(XIO_LAST);
  localparam logic [AW-1:0] SnL  = AW'(SRAM_LAST_NORM);
  localparam logic [AW-1:0] ScL  = AW'(SRAM_LAST_COMPAT);

  logic [AW-1:0] sram_last;
  assign sram_last = compat_i ? ScL : SnL;

  always_comb begin
    if (addr_i <= RfL)                   region_o = RGN_RF;
    else if (addr_i <= IoL)              region_o = RGN_IO;
    else if (!compat_i && addr_i <= XioL) region_o = RGN_XIO;
    else if (addr_i <= sram_last)        region_o = RGN_SRAM;
    else                                 region_o = RGN_EXT;
  end
endmodule

// File: rtl/dsd_ext_ctrl.sv
module dsd_ext_ctrl #(
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 8,
  parameter int unsigned WSW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [WSW-1:0] ws_i,
  output logic           busy_o,
  output logic           more_o,
  output logic [AW-1:0]  ext_addr_o,
  output logic [DW-1:0]  ext_wdata_o,
  output logic           ext_rd_no,
  output logic           ext_wr_no
);
  logic           busy_q, wr_q;
  logic [WSW-1:0] cnt_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;

  // wait count and direction are latched once, at the start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q  <= 1'b1;
        wr_q    <= wr_i;
        cnt_q   <= ws_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign more_o      = busy_q && (cnt_q != '0);
  assign ext_addr_o  = addr_q;
  assign ext_wdata_o = wdata_q;
  assign ext_rd_no   = !(busy_q && !wr_q);
  assign ext_wr_no   = !(busy_q && wr_q);
endmodule

// File: rtl/dsd_rdata_mux.sv
module dsd_rdata_mux #(
  parameter int unsigned DW = 8,
  parameter int unsigned NT = 4
) (
  input  logic [NT-1:0]        sel_i,
  input  logic [NT-1:0][DW-1:0] tdata_i,
  input  logic                 ext_act_i,
  input  logic [DW-1:0]        ext_data_i,
  output logic [DW-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(NT); i++) begin
      if (sel_i[i]) rdata_o = rdata_o | tdata_i[i];
    end
    if (ext_act_i) rdata_o = ext_data_i;
  end
endmodule

// File: rtl/data_space_decoder.sv
module data_space_decoder
  import dsd_pkg::*;
#(
  parameter int unsigned AW               = 16,
  parameter int unsigned DW               = 8,
  parameter int unsigned WSW              = 2,
  parameter int unsigned RF_LAST          = 32'h001F,
  parameter int unsigned IO_LAST          = 32'h005F,
  parameter int unsigned XIO_LAST         = 32'h00FF,
  parameter int unsigned SRAM_LAST_NORM   = 32'h10FF,
  parameter int unsigned SRAM_LAST_COMPAT = 32'h0FFF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic           rd_i,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           compat_i,
  input  logic           xmem_en_i,
  input  logic [WSW-1:0] wait_i,
  output logic [DW-1:0]  rdata_o,
  output logic           stall_o,
  output logic           decode_err_o,
  output logic [3:0]     sel_o,
  input  logic [DW-1:0]  rf_rdata_i,
  input  logic [DW-1:0]  io_rdata_i,
  input  logic [DW-1:0]  xio_rdata_i,
  input  logic [DW-1:0]  sram_rdata_i,
  output logic [AW-1:0]  ext_addr_o,
  output logic [DW-1:0]  ext_wdata_o,
  input  logic [DW-1:0]  ext_rdata_i,
  output logic           ext_rd_no,
  output logic           ext_wr_no
);
  localparam int unsigned NT = 4;

  region_e region;
  logic    busy, more, req_idle, ext_hit, start;
  logic [NT-1:0][DW-1:0] tdata;

  dsd_region_decode #(
    .AW(AW), .RF_LAST(RF_LAST), .IO_LAST(IO_LAST), .XIO_LAST(XIO_LAST),
    .SRAM_LAST_NORM(SRAM_LAST_NORM), .SRAM_LAST_COMPAT(SRAM_LAST_COMPAT)
  ) u_dec (
    .addr_i   (addr_i),
    .compat_i (compat_i),
    .region_o (region)
  );

  assign req_idle = (rd_i || wr_i) && !busy;
  assign ext_hit  = req_idle && (region == RGN_EXT);
  assign start    = ext_hit && xmem_en_i;

  for (genvar g = 0; g < int'(NT); g++) begin : g_sel
    assign sel_o[g] = req_idle && (region == region_e'(g));
  end

  assign tdata[0] = rf_rdata_i;
  assign tdata[1] = io_rdata_i;
  assign tdata[2] = xio_rdata_i;
  assign tdata[3] = sram_rdata_i;

  dsd_ext_ctrl #(.AW(AW), .DW(DW), .WSW(WSW)) u_ext (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ws_i        (wait_i),
    .busy_o      (busy),
    .more_o      (more),
    .ext_addr_o  (ext_addr_o),
    .ext_wdata_o (ext_wdata_o),
    .ext_rd_no   (ext_rd_no),
    .ext_wr_no   (ext_wr_no)
  );

  dsd_rdata_mux #(.DW(DW), .NT(NT)) u_mux (
    .sel_i      (sel_o),
    .tdata_i    (tdata),
    .ext_act_i  (!ext_rd_no),
    .ext_data_i (ext_rdata_i),
    .rdata_o    (rdata_o)
  );

  assign stall_o      = start || more;
  assign decode_err_o = ext_hit && !xmem_en_i;
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    sel_o,
  input logic          stall_o,
  input logic          decode_err_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW-1:0] ext_addr_o,
  input logic [DW-1:0] ext_wdata_o,
  input logic          ext_rd_no,
  input logic          ext_wr_no
);
  logic strobe;
  assign strobe = !ext_rd_no || !ext_wr_no;

  assert_onehot_sel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  assert_int_strobe_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sel_o) |-> (ext_rd_no && ext_wr_no));

  assert_err_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_err_o |-> (sel_o == 4'b0 && ext_rd_no && ext_wr_no && rdata_o == '0 && !stall_o));

  assert_single_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ext_rd_no && !ext_wr_no));

  assert_bus_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && $past(strobe)) |-> ($stable(ext_addr_o) && $stable(ext_wdata_o)));

  assert_strobe_after_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !$past(strobe)) |-> $past(stall_o));

  assert_strobe_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && strobe) |=> strobe);
endmodule

bind data_space_decoder dsd_checker #(.AW(AW), .DW(DW)) u_dsd_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_o        (sel_o),
  .stall_o      (stall_o),
  .decode_err_o (decode_err_o),
  .rdata_o      (rdata_o),
  .ext_addr_o   (ext_addr_o),
  .ext_wdata_o  (ext_wdata_o),
  .ext_rd_no    (ext_rd_no),
  .ext_wr_no    (ext_wr_no)
);

// File: tb/tb_data_space_decoder.sv
`timescale 1ns/100ps
module tb_data_space_decoder;
  localparam logic [7:0] D_RF = 8'hA1, D_IO = 8'hB2, D_XIO = 8'hC3, D_SR = 8'hD4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0, compat = 1'b0, xen = 1'b0;
  logic [7:0]  wdata = '0;
  logic [1:0]  wsel = '0;
  logic [7:0]  rdata, ext_wdata, ext_rdata;
  logic        stall, derr, ext_rd_n, ext_wr_n;
  logic [3:0]  sel;
  logic [15:0] ext_addr;
  logic [7:0]  xmem [256];
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  data_space_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .compat_i(compat), .xmem_en_i(xen), .wait_i(wsel),
    .rdata_o(rdata), .stall_o(stall), .decode_err_o(derr), .sel_o(sel),
    .rf_rdata_i(D_RF), .io_rdata_i(D_IO), .xio_rdata_i(D_XIO), .sram_rdata_i(D_SR),
    .ext_addr_o(ext_addr), .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata),
    .ext_rd_no(ext_rd_n), .ext_wr_no(ext_wr_n)
  );

  assign ext_rdata = ext_rd_n ? 8'h00 : xmem[ext_addr[7:0]];
  always @(posedge clk) if (!ext_wr_n) xmem[ext_addr[7:0]] <= ext_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected region index: 0 rf, 1 io, 2 xio, 3 sram, 4 external
  function automatic int exp_region(input int a, input bit cm);
    int top = cm ? 32'h0FFF : 32'h10FF;
    if (a < 32) return 0;
    if (a < 32 + 64) return 1;
    if (!cm && a < 256) return 2;
    if (a <= top) return 3;
    return 4;
  endfunction

  task automatic sweep(input bit cm);
    int a = 0;
    while (a < 65536) begin
      int r = exp_region(a, cm);
      logic [3:0] es = (r < 4) ? 4'(1 << r) : 4'b0;
      logic [7:0] ed;
      bit is_wr = a[0];
      case (r)
        0: ed = D_RF; 1: ed = D_IO; 2: ed = D_XIO; 3: ed = D_SR; default: ed = 8'h00;
      endcase
      @(negedge clk);
      compat = cm; xen = 1'b0; addr = 16'(a); rd = !is_wr; wr = is_wr;
      #1;
      // R1 R2 R4 R5 R10: select, strobes, error flag, read data
      check(sel === es && ext_rd_n && ext_wr_n && derr === (r == 4) && !stall
            && (is_wr || rdata === ed),
            cm ? "R2/R4/R5/R10 sweep" : "R1/R4/R5/R10 sweep",
            {a, sel, 3'b0, derr}, {a, es, 3'b0, r == 4});
      a = (a < 32'h1200) ? a + 1 : a + 32'h100;
      if (a == 32'h10000 - 32'h100 + 32'h100) a = 65536;
    end
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    // last address explicitly
    @(negedge clk); addr = 16'hFFFF; rd = 1'b1; #1;
    check(sel === 4'b0 && derr === 1'b1 && rdata === 8'h00, "R4 top address", {sel, derr}, 1);
    rd = 1'b0;
  endtask

  task automatic ext_access(input logic [15:0] a, input bit is_wr, input logic [7:0] d,
                            input int ws, input logic [7:0] exp_rd, input bit mid_change,
                            input string tag);
    int stalls = 0, strobes = 0;
    bit bad_bus = 0, done = 0, both = 0;
    logic [7:0] got = '0;
    bit cm0 = compat;
    @(negedge clk);
    xen = 1'b1; addr = a; rd = !is_wr; wr = is_wr; wdata = d; wsel = 2'(ws);
    for (int k = 0; k < 12 && !done; k++) begin
      #1;
      if (stall) stalls++;
      if (!ext_rd_n && !ext_wr_n) both = 1;
      if ((is_wr ? !ext_wr_n : !ext_rd_n)) begin
        strobes++;
        if (ext_addr !== a || (is_wr && ext_wdata !== d)) bad_bus = 1;
      end
      if (sel !== 4'b0) bad_bus = 1;
      if (!stall) begin
        got = rdata; done = 1; rd = 1'b0; wr = 1'b0;
      end else begin
        @(negedge clk);
        if (mid_change && k == 0) begin wsel = ~wsel; compat = !compat; end
      end
    end
    @(negedge clk); compat = cm0; #1;
    check(stalls == ws + 1, {tag, " R6 stall cycles"}, stalls, ws + 1);
    check(strobes == ws + 1 && !both, {tag, " R7 strobe cycles"}, strobes, ws + 1);
    check(!bad_bus, {tag, " R3/R7 bus held"}, bad_bus, 0);
    if (!is_wr) check(got === exp_rd, {tag, " R8 read data"}, got, exp_rd);
    check(ext_rd_n && ext_wr_n && !stall, {tag, " R7 bus idle after"}, {ext_rd_n, ext_wr_n}, 3);
  endtask

  initial begin
    #20000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) xmem[i] = 8'(i) ^ 8'h5A;
    #1;
    check(!stall && ext_rd_n && ext_wr_n && sel === 4'b0, "R11 in reset", {stall, sel}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(!stall && ext_rd_n && ext_wr_n && sel === 4'b0 && !derr, "R11 after reset", {stall, sel}, 0);

    sweep(1'b0);
    sweep(1'b1);

    // external reads at the range edges, all wait settings
    for (int w = 0; w < 4; w++) begin
      compat = 1'b0;
      ext_access(16'h1100, 1'b0, 8'h00, w, 8'h00 ^ 8'h5A, 1'b0, "R3 norm first ext");
      ext_access(16'hFFFF, 1'b0, 8'h00, w, 8'hFF ^ 8'h5A, 1'b0, "R3 norm top");
      compat = 1'b1;
      ext_access(16'h1000, 1'b0, 8'h00, w, 8'h00 ^ 8'h5A, 1'b0, "R3 compat first ext");
    end
    // write then read back, each wait setting
    compat = 1'b0;
    for (int w = 0; w < 4; w++) begin
      logic [15:0] a = 16'h2000 + 16'(w * 16'h0111);
      logic [7:0]  v = 8'h30 + 8'(w * 17);
      ext_access(a, 1'b1, v, w, 8'h00, 1'b0, "R8 write");
      ext_access(a, 1'b0, 8'h00, 3 - w, v, 1'b0, "R8 readback");
    end
    // mode and wait changed mid-access: 0x1080 is external only in compat layout
    compat = 1'b1;
    ext_access(16'h1080, 1'b0, 8'h00, 0, 8'h80 ^ 8'h5A, 1'b1, "R9 ws0");
    ext_access(16'h1081, 1'b0, 8'h00, 2, 8'h81 ^ 8'h5A, 1'b1, "R9 ws2");
    ext_access(16'h1082, 1'b1, 8'h6C, 3, 8'h00, 1'b1, "R9 wr ws3");
    ext_access(16'h1082, 1'b0, 8'h00, 1, 8'h6C, 1'b0, "R9 readback");
    // R9: same address is internal in normal layout
    compat = 1'b0;
    @(negedge clk); addr = 16'h1080; rd = 1'b1; #1;
    check(sel === 4'b1000 && !stall && rdata === D_SR, "R1 0x1080 normal is SRAM", sel, 8);
    @(negedge clk); rd = 1'b0;

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule